// File: doc/BRIEF.md
# Converter Fault Hiccup Controller

This block watches the per-cycle fault flags of a synchronous buck converter and decides when the power stage must stop and restart. On every PWM cycle strobe it samples three comparator flags: overcurrent, undervoltage and overvoltage. Each flag has its own counter of consecutive faulty cycles. When a counter reaches its limit, the block starts a hiccup. A hiccup first discharges the soft-start node. It waits for the discharge-complete indication and then releases the node so that a new soft-start ramp begins.

An overvoltage that lasts long enough does not hiccup at once. It latches the converter off with the drivers tri-stated. Once the output has then sagged to the undervoltage level for enough cycles, the normal hiccup follows. An over-temperature trip stops switching until a separate temperature-clear indication arrives. Losing the supply-good signal or the enable holds everything off. A status code keeps the cause of the most recent shutdown until a soft-start has completed without interruption.

Top module: `fault_hiccup_ctrl`

## Requirements
- R1: While `rst` is high, or `por_ok` or `en` is low, the outputs from the next clock edge are `ss_discharge`=1, `ss_release`=0 and `drv_tristate`=1, and the block stays in that state whatever `dis_done` does.
- R2: Once `por_ok` and `en` are high with no over-temperature, the block holds `ss_discharge`=1 until it samples `dis_done` high. On that edge it moves to `ss_release`=1, `ss_discharge`=0 and `drv_tristate`=0.
- R3: While running with `ss_active` low, `oc_flag` sampled on 8 consecutive `cyc_tick` strobes starts a hiccup (`ss_discharge`=1, `drv_tristate`=1) on the edge of the 8th strobe, and sets `fault_code`=1. Seven strobes leave the block running.
- R4: The overcurrent count is held at zero while `ss_active` is high. Overcurrent strobes during soft-start count toward nothing, and only 8 consecutive strobes after `ss_active` falls cause a trip.
- R5: A strobe on which a given flag is low clears that flag's consecutive count to zero.
- R6: `uv_flag` sampled on 8 consecutive strobes while running starts the same hiccup and sets `fault_code`=2.
- R7: `ov_flag` sampled on 32 consecutive strobes while running latches the block off with `drv_tristate`=1, `ss_discharge`=0 and `ss_release`=0, and sets `fault_code`=3. 31 strobes leave it running.
- R8: In the overvoltage-latched state, 8 consecutive `uv_flag` strobes start the hiccup discharge; `fault_code` stays 3.
- R9: `ot_trip` high (with `por_ok` and `en` high) gives `drv_tristate`=1, `ss_discharge`=1 and `fault_code`=4 on the next edge. The block ignores `dis_done` until it samples `ot_clr` high with `ot_trip` low, and then it enters the discharge-and-release sequence of R2.
- R10: `fault_code` (0 none, 1 overcurrent, 2 undervoltage, 3 overvoltage, 4 over-temperature) holds its value until `ss_active` falls while the block is running, and then returns to 0.
- R11: Fault flags are only sampled on cycles where `cyc_tick` is high; flags held high without a strobe have no effect.
- R12: `ss_discharge` and `ss_release` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One-cycle strobe per PWM period |
| oc_flag | input | 1 | Overcurrent seen in this PWM period |
| uv_flag | input | 1 | Feedback below undervoltage level |
| ov_flag | input | 1 | Feedback above overvoltage level |
| ss_active | input | 1 | Soft-start ramp in progress |
| por_ok | input | 1 | Supply above power-on-reset threshold |
| en | input | 1 | Converter enable |
| ot_trip | input | 1 | Over-temperature trip |
| ot_clr | input | 1 | Temperature back below clear level |
| dis_done | input | 1 | Soft-start node fully discharged |
| ss_discharge | output | 1 | Request to discharge soft-start node |
| ss_release | output | 1 | Soft-start node released to ramp |
| drv_tristate | output | 1 | Gate drivers to high impedance |
| fault_code | output | 3 | Cause of the last shutdown |

## Verification
Every output is a register loaded from the next-state logic. A strobe or control change that is sampled on one rising edge therefore shows its effect right after that same edge, with no further latency. A discharge-to-release step takes one edge after `dis_done`, and the code clear takes one edge after `ss_active` falls. The bench drives inputs on falling edges, holds a strobe for exactly one rising edge, and reads the outputs on the next falling edge. Each boundary is checked one strobe short of the limit and again at the limit.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_RUN     = 3'd2,
    ST_OVLATCH = 3'd3,
    ST_HOT     = 3'd4
  } hic_state_t;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0,
    FC_OC   = 3'd1,
    FC_UV   = 3'd2,
    FC_OV   = 3'd3,
    FC_OT   = 3'd4
  } fault_code_t;

  localparam int NUM_FAULT_CNT = 3;
  localparam int IDX_OC = 0;
  localparam int IDX_UV = 1;
  localparam int IDX_OV = 2;
endpackage

// File: rtl/consec_counter.sv
module consec_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic hit,
  output logic trip
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign trip = tick && hit && !clr && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick) begin
      if (!hit || trip) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(LIMIT)); // R5
  AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (tick && !hit) |=> (cnt == '0)); // R5
endmodule

// File: rtl/hiccup_fsm.sv
module hiccup_fsm
  import hiccup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       por_ok,
  input  logic       en,
  input  logic       ot_trip,
  input  logic       ot_clr,
  input  logic       dis_done,
  input  logic       oc_trip,
  input  logic       uv_trip,
  input  logic       ov_trip,
  output hic_state_t st,
  output logic       ev_oc,
  output logic       ev_uv,
  output logic       ev_ov,
  output logic       ev_ot,
  output logic       ss_discharge,
  output logic       ss_release,
  output logic       drv_tristate
);
  hic_state_t nxt;

  always_comb begin
    nxt   = st;
    ev_oc = 1'b0;
    ev_uv = 1'b0;
    ev_ov = 1'b0;
    ev_ot = 1'b0;
    if (!por_ok || !en) begin
      nxt = ST_OFF;
    end else if (ot_trip) begin
      nxt   = ST_HOT;
      ev_ot = (st != ST_HOT);
    end else begin
      unique case (st)
        ST_OFF:   nxt = ST_DRAIN;
        ST_DRAIN: if (dis_done) nxt = ST_RUN;
        ST_RUN: begin
          if (ov_trip) begin
            nxt   = ST_OVLATCH;
            ev_ov = 1'b1;
          end else if (oc_trip) begin
            nxt   = ST_DRAIN;
            ev_oc = 1'b1;
          end else if (uv_trip) begin
            nxt   = ST_DRAIN;
            ev_uv = 1'b1;
          end
        end
        ST_OVLATCH: if (uv_trip) nxt = ST_DRAIN;
        ST_HOT:     if (ot_clr)  nxt = ST_DRAIN;
        default:    nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_OFF;
      ss_discharge <= 1'b1;
      ss_release   <= 1'b0;
      drv_tristate <= 1'b1;
    end else begin
      st           <= nxt;
      ss_discharge <= (nxt == ST_OFF) || (nxt == ST_DRAIN) || (nxt == ST_HOT);
      ss_release   <= (nxt == ST_RUN);
      drv_tristate <= (nxt != ST_RUN);
    end
  end

  AST_HOT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOT && por_ok && en && !ot_clr) |=> (st == ST_HOT)); // R9
endmodule

// File: rtl/fault_code_reg.sv
module fault_code_reg
  import hiccup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_oc,
  input  logic       ev_uv,
  input  logic       ev_ov,
  input  logic       ev_ot,
  input  logic       running,
  input  logic       ss_active,
  output logic [2:0] code
);
  logic ss_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= FC_NONE;
      ss_q <= 1'b0;
    end else begin
      ss_q <= ss_active;
      if      (ev_ot) code <= FC_OT;
      else if (ev_ov) code <= FC_OV;
      else if (ev_oc) code <= FC_OC;
      else if (ev_uv) code <= FC_UV;
      else if (running && ss_q && !ss_active) code <= FC_NONE;
    end
  end

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    code <= FC_OT); // R10
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!running && !ev_oc && !ev_uv && !ev_ov && !ev_ot) |=> $stable(code)); // R10
endmodule

// File: rtl/fault_hiccup_ctrl.sv
module fault_hiccup_ctrl
  import hiccup_pkg::*;
#(
  parameter int OC_LIMIT = 8,
  parameter int UV_LIMIT = 8,
  parameter int OV_LIMIT = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cyc_tick,
  input  logic       oc_flag,
  input  logic       uv_flag,
  input  logic       ov_flag,
  input  logic       ss_active,
  input  logic       por_ok,
  input  logic       en,
  input  logic       ot_trip,
  input  logic       ot_clr,
  input  logic       dis_done,
  output logic       ss_discharge,
  output logic       ss_release,
  output logic       drv_tristate,
  output logic [2:0] fault_code
);
  hic_state_t st;
  logic [NUM_FAULT_CNT-1:0] hit, clr, trip;
  logic ev_oc, ev_uv, ev_ov, ev_ot;

  assign hit[IDX_OC] = oc_flag;
  assign hit[IDX_UV] = uv_flag;
  assign hit[IDX_OV] = ov_flag;

  // overcurrent count is forced to zero through the whole soft-start ramp
  assign clr[IDX_OC] = (st != ST_RUN) || ss_active;
  // undervoltage also counts in the overvoltage latch; restart it on entry
  assign clr[IDX_UV] = !((st == ST_RUN) || (st == ST_OVLATCH)) || (st == ST_RUN && trip[IDX_OV]);
  assign clr[IDX_OV] = (st != ST_RUN);

  for (genvar g = 0; g < NUM_FAULT_CNT; g++) begin : g_cnt
    localparam int LIM = (g == IDX_OC) ? OC_LIMIT :
                         (g == IDX_UV) ? UV_LIMIT : OV_LIMIT;
    consec_counter #(.LIMIT(LIM)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr[g]),
      .tick (cyc_tick),
      .hit  (hit[g]),
      .trip (trip[g])
    );
  end

  hiccup_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .por_ok       (por_ok),
    .en           (en),
    .ot_trip      (ot_trip),
    .ot_clr       (ot_clr),
    .dis_done     (dis_done),
    .oc_trip      (trip[IDX_OC]),
    .uv_trip      (trip[IDX_UV]),
    .ov_trip      (trip[IDX_OV]),
    .st           (st),
    .ev_oc        (ev_oc),
    .ev_uv        (ev_uv),
    .ev_ov        (ev_ov),
    .ev_ot        (ev_ot),
    .ss_discharge (ss_discharge),
    .ss_release   (ss_release),
    .drv_tristate (drv_tristate)
  );

  fault_code_reg u_code (
    .clk       (clk),
    .rst       (rst),
    .ev_oc     (ev_oc),
    .ev_uv     (ev_uv),
    .ev_ov     (ev_ov),
    .ev_ot     (ev_ot),
    .running   (st == ST_RUN),
    .ss_active (ss_active),
    .code      (fault_code)
  );

  AST_DRAIN_RELEASE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ss_discharge && ss_release)); // R12
  AST_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!por_ok || !en) |=> (drv_tristate && ss_discharge && !ss_release)); // R1
  AST_HOT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (por_ok && en && ot_trip) |=> (drv_tristate && ss_discharge)); // R9
  AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_release) |-> $past(dis_done)); // R2
  AST_NO_STROBE_NO_TRIP: assert property (@(posedge clk) disable iff (rst)
    (ss_release && !cyc_tick && por_ok && en && !ot_trip) |=> ss_release); // R11
  AST_OC_IDLE_IN_SS: assert property (@(posedge clk) disable iff (rst)
    (ss_active && ss_release && !uv_flag && !ov_flag && por_ok && en && !ot_trip) |=> ss_release); // R4
endmodule

// File: tb/tb_fault_hiccup_ctrl.sv
module tb_fault_hiccup_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_tick = 0, oc_flag = 0, uv_flag = 0, ov_flag = 0;
  logic ss_active = 0, por_ok = 0, en = 0, ot_trip = 0, ot_clr = 0, dis_done = 0;
  logic ss_discharge, ss_release, drv_tristate;
  logic [2:0] fault_code;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_hiccup_ctrl dut (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .oc_flag(oc_flag), .uv_flag(uv_flag),
    .ov_flag(ov_flag), .ss_active(ss_active), .por_ok(por_ok), .en(en),
    .ot_trip(ot_trip), .ot_clr(ot_clr), .dis_done(dis_done),
    .ss_discharge(ss_discharge), .ss_release(ss_release),
    .drv_tristate(drv_tristate), .fault_code(fault_code)
  );

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // compare {discharge, release, tristate} and fault code
  task automatic chk_out(input string req, input logic [2:0] dsr, input logic [2:0] code);
    chk(req, {ss_discharge, ss_release, drv_tristate, fault_code}, {dsr, code});
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic strobe(input logic oc, input logic uv, input logic ov);
    cyc_tick = 1; oc_flag = oc; uv_flag = uv; ov_flag = ov;
    step();
    cyc_tick = 0; oc_flag = 0; uv_flag = 0; ov_flag = 0;
  endtask

  task automatic strobes(input int n, input logic oc, input logic uv, input logic ov);
    for (int i = 0; i < n; i++) strobe(oc, uv, ov);
  endtask

  // discharge done, then one clean soft-start pulse
  task automatic restart(input string req);
    dis_done = 1; step(); dis_done = 0;
    ss_active = 1; step(); ss_active = 0; step();
    chk_out(req, 3'b010, 3'd0);
  endtask

  task automatic t_reset();
    step();
    chk_out("R1 reset", 3'b101, 3'd0);
    rst = 0; step(); step();
    chk_out("R1 por/en low after reset", 3'b101, 3'd0);
  endtask

  task automatic t_start();
    por_ok = 1; en = 1; step();
    chk_out("R2 draining", 3'b101, 3'd0);
    step(); step(); step();
    chk_out("R2 waits for dis_done", 3'b101, 3'd0);
    dis_done = 1; step(); dis_done = 0;
    chk_out("R2 released", 3'b010, 3'd0);
  endtask

  task automatic t_oc();
    strobes(7, 1, 0, 0);
    chk_out("R3 seven OC", 3'b010, 3'd0);
    strobe(1, 0, 0);
    chk_out("R3 eighth OC hiccup", 3'b101, 3'd1);
    dis_done = 1; step(); dis_done = 0;
    chk_out("R10 code held after restart", 3'b010, 3'd1);
    ss_active = 1; step(); ss_active = 0; step();
    chk_out("R10 code cleared after soft-start", 3'b010, 3'd0);
  endtask

  task automatic t_oc_in_ss();
    ss_active = 1;
    strobes(10, 1, 0, 0);
    chk_out("R4 OC ignored in soft-start", 3'b010, 3'd0);
    strobes(5, 1, 0, 0);
    ss_active = 0;
    strobes(7, 1, 0, 0);
    chk_out("R4 count restarted after soft-start", 3'b010, 3'd0);
    strobe(1, 0, 0);
    chk_out("R4 trip after 8 post soft-start", 3'b101, 3'd1);
    restart("R4 restart");
  endtask

  task automatic t_clear();
    strobes(7, 1, 0, 0);
    strobe(0, 0, 0);
    strobes(7, 1, 0, 0);
    chk_out("R5 clean strobe clears count", 3'b010, 3'd0);
    strobe(1, 0, 0);
    chk_out("R5 eight consecutive trip", 3'b101, 3'd1);
    restart("R5 restart");
    strobes(7, 0, 1, 0);
    strobe(0, 0, 0);
    strobes(7, 0, 1, 0);
    chk_out("R5 UV clean strobe clears count", 3'b010, 3'd0);
    strobe(0, 0, 0);
  endtask

  task automatic t_uv();
    strobes(7, 0, 1, 0);
    chk_out("R6 seven UV", 3'b010, 3'd0);
    strobe(0, 1, 0);
    chk_out("R6 UV hiccup", 3'b101, 3'd2);
    restart("R6 restart");
  endtask

  task automatic t_ov();
    strobes(31, 0, 0, 1);
    chk_out("R7 31 OV", 3'b010, 3'd0);
    strobe(0, 0, 1);
    chk_out("R7 OV latch off", 3'b001, 3'd3);
    dis_done = 1; step(); step(); dis_done = 0;
    chk_out("R7 latch holds", 3'b001, 3'd3);
    strobes(7, 0, 1, 0);
    chk_out("R8 seven UV in latch", 3'b001, 3'd3);
    strobe(0, 1, 0);
    chk_out("R8 UV after OV hiccup", 3'b101, 3'd3);
    restart("R8 restart");
  endtask

  task automatic t_no_strobe();
    oc_flag = 1; uv_flag = 1; ov_flag = 1;
    for (int i = 0; i < 40; i++) step();
    oc_flag = 0; uv_flag = 0; ov_flag = 0;
    chk_out("R11 flags without strobe ignored", 3'b010, 3'd0);
  endtask

  task automatic t_ot();
    ot_trip = 1; step(); ot_trip = 0;
    chk_out("R9 over-temp stop", 3'b101, 3'd4);
    dis_done = 1; step(); step(); step(); dis_done = 0;
    chk_out("R9 stays off without clear", 3'b101, 3'd4);
    ot_clr = 1; step(); ot_clr = 0;
    chk_out("R9 draining after clear", 3'b101, 3'd4);
    dis_done = 1; step(); dis_done = 0;
    chk_out("R9 released after clear", 3'b010, 3'd4);
    ss_active = 1; step(); ss_active = 0; step();
    chk_out("R10 OT code cleared", 3'b010, 3'd0);
  endtask

  task automatic t_disable();
    en = 0; step();
    chk_out("R1 enable low", 3'b101, 3'd0);
    en = 1; por_ok = 0; dis_done = 1;
    step(); step(); step();
    chk_out("R1 POR low holds off", 3'b101, 3'd0);
    por_ok = 1; step(); step(); dis_done = 0;
    chk_out("R1 restart once POR ok", 3'b010, 3'd0);
    strobe(0, 0, 0);
    chk_out("R12 run outputs exclusive", 3'b010, 3'd0);
  endtask

  initial begin
    t_reset();
    t_start();
    t_oc();
    t_oc_in_ss();
    t_clear();
    t_uv();
    t_ov();
    t_no_strobe();
    t_ot();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule